// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block lets a plain byte-read port fetch data straight out of serial NOR flash devices. Every read request that lands in the mapped address range becomes a complete flash read transaction: a command byte, an address of three or four bytes, an optional run of dummy clocks, then the data phase. The requested byte comes back on the read port together with a one-cycle ready strobe.

One 32-bit configuration word sets the read sequence: the opcode, the address length, the dummy amount, the lane mode (one, two or four data lanes) and whether each access fetches a single byte or a 16-byte burst. The mapped range is cut into equal windows, one per chip-select. The window an address falls in picks the device. The offset inside that window is the flash address. A lock bit freezes the configuration until the next reset.

The serial clock runs at half the core clock in mode 0: it idles low, outgoing bits change while it is low, and incoming bits are taken on its rising edge. The requester holds the request and the address until ready, then drops the request. A request is accepted only while no flash transaction is in flight.

Top module: `mmflash_rd_xlat`

## Requirements
- R1: After reset every chip-select is high, the serial clock is low, ready is low and the configuration reads back as zero.
- R2: Each access starts with the 8-bit opcode from configuration bits 7:0, sent most significant bit first on lane 0 over 8 serial clocks.
- R3: Configuration bits 9:8 pick the lane mode for the address and data phases: 0 uses one lane (out on io0, in on io1), 1 uses io1:io0, 2 uses io3:io0 with the higher lane carrying the earlier bit, and 3 is reserved and behaves as 0. The opcode always uses one lane.
- R4: Configuration bits 17:16 give the address length: 0 sends the low 24 bits of the window offset, any other value sends 32 bits, most significant first.
- R5: Configuration bits 13:12 hold a dummy count D. After the address, 8*D serial clocks run with every io output enable low, and the enables stay low through the data phase.
- R6: When configuration bits 25:24 equal 3, each access reads 16 bytes from the offset rounded down to a multiple of 16. Any other value reads one byte at the offset itself.
- R7: Ready is a one-cycle pulse, raised in the cycle after the last bit of the requested byte is taken, with that byte on the read data. In a burst it can come before the flash transaction ends.
- R8: The chip-select index is the address divided by the window size (128 MB by default, address bits 28:27). At most one active-low select is asserted at any time.
- R9: Once bit 31 of the configuration is 1, configuration writes are ignored until reset. Undefined bits always read as 0.
- R10: The serial clock pulses only while a select is asserted and is never high for two core cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Current configuration word |
| rd_req | input | 1 | Read request, held until ready |
| rd_addr | input | ADDR_W | Byte address in the mapped range |
| rd_ready | output | 1 | One-cycle strobe, read data valid |
| rd_data | output | 8 | Returned byte |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low chip-selects |
| spi_io_out | output | 4 | Serial data outputs, lanes 3..0 |
| spi_io_oe | output | 4 | Output enables for the lanes |
| spi_io_in | input | 4 | Serial data inputs, lanes 3..0 |

## Verification
The embedded properties watch, on every cycle, the invariants of the serial interface and the handshake: at most one select low, a clock that never stays high and never runs without a select, a ready that is a lone pulse and only follows a cycle with a device selected, and a locked configuration that never changes. What goes on the wire, namely the opcode bits, the address value and its width, the dummy length, the lane mapping, the burst alignment and which byte is returned, can only be shown by the scenarios. There a behavioural flash model decodes the wire traffic and supplies data that depends on the address. Locking and the release of the lock by reset are also shown by directed scenarios only.

// File: rtl/mmflash_pkg.sv
package mmflash_pkg;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_RSV = 2'd3
  } lane_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] burst;
    logic [1:0] alen;
    logic [1:0] dummy;
    lane_mode_e mode;
    logic [7:0] opcode;
  } rd_cfg_t;

  localparam logic [31:0] CFG_MASK = 32'h8303_33FF;

  function automatic rd_cfg_t cfg_decode(input logic [31:0] w);
    rd_cfg_t c;
    c.lock   = w[31];
    c.burst  = w[25:24];
    c.alen   = w[17:16];
    c.dummy  = w[13:12];
    c.mode   = lane_mode_e'(w[9:8]);
    c.opcode = w[7:0];
    return c;
  endfunction

  // log2 of the lane count; the reserved mode falls back to one lane
  function automatic logic [1:0] mode_lg(input lane_mode_e m);
    logic [1:0] r;
    case (m)
      LANE_X2: r = 2'd1;
      LANE_X4: r = 2'd2;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mmflash_cfg_reg.sv
module mmflash_cfg_reg
  import mmflash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] cfg_word,
  output rd_cfg_t     cfg
);

  logic [31:0] cfg_q, cfg_d;
  logic        cfg_en;

  assign cfg_en = wr_en && !cfg_q[31];

  always_comb begin
    cfg_d = wr_data & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_word = cfg_q;
  assign cfg      = cfg_decode(cfg_q);

  assert_lock_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[31] |=> $stable(cfg_q));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[31] |=> cfg_q[31]);

endmodule

// File: rtl/mmflash_addr_map.sv
module mmflash_addr_map #(
  parameter int ADDR_W = 29,
  parameter int WIN_W  = 27,
  parameter int NUM_CS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst,
  output logic [NUM_CS-1:0] cs_sel,
  output logic [31:0]       flash_addr,
  output logic [3:0]        byte_sel
);

  localparam int CS_W = ADDR_W - WIN_W;

  logic [CS_W-1:0] cs_idx;
  logic [31:0]     offset;

  assign cs_idx = addr[ADDR_W-1:WIN_W];
  assign offset = 32'(addr[WIN_W-1:0]);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_sel[g] = (cs_idx == CS_W'(g));
  end

  always_comb begin
    if (burst) begin
      flash_addr = {offset[31:4], 4'h0};
      byte_sel   = offset[3:0];
    end else begin
      flash_addr = offset;
      byte_sel   = 4'h0;
    end
  end

endmodule

// File: rtl/mmflash_spi_seq.sv
module mmflash_spi_seq
  import mmflash_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int DUMMY_UNIT = 8,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rd_cfg_t           cfg,
  input  logic [31:0]       flash_addr,
  input  logic [NUM_CS-1:0] cs_sel,
  input  logic [3:0]        io_in,
  output logic              idle,
  output logic              sck,
  output logic [NUM_CS-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              byte_vld,
  output logic [7:0]        byte_dat,
  output logic [3:0]        byte_idx
);

  phase_e            phase_q, phase_d;
  logic              half_q, half_d;
  logic              sck_q, sck_d;
  logic [NUM_CS-1:0] cs_n_q, cs_n_d;
  logic [31:0]       sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        bitc_q, bitc_d;
  logic [7:0]        rx_q, rx_d, rx_nxt;
  logic [3:0]        bidx_q, bidx_d;
  logic [1:0]        lg_q, lg_d;
  logic              alen4_q, alen4_d;
  logic [1:0]        dum_q, dum_d;
  logic              burst_q, burst_d;
  logic [31:0]       addr_q, addr_d;
  logic              seq_en;

  logic [CNT_W-1:0]  addr_beats, dum_beats, data_beats;
  logic [2:0]        last_bit, lane_n;
  logic              byte_end;

  assign lane_n     = 3'(1 << lg_q);
  assign last_bit   = 3'(7 >> lg_q);
  assign addr_beats = (alen4_q ? CNT_W'(32) : CNT_W'(24)) >> lg_q;
  assign dum_beats  = CNT_W'(dum_q) * CNT_W'(DUMMY_UNIT);
  assign data_beats = (burst_q ? CNT_W'(128) : CNT_W'(8)) >> lg_q;
  assign byte_end   = (phase_q == PH_DATA) && half_q && (bitc_q == last_bit);

  always_comb begin
    case (lg_q)
      2'd0:    rx_nxt = {rx_q[6:0], io_in[1]};
      2'd1:    rx_nxt = {rx_q[5:0], io_in[1:0]};
      default: rx_nxt = {rx_q[3:0], io_in};
    endcase
  end

  // next-state logic
  always_comb begin
    phase_d = phase_q;  half_d  = half_q;  sck_d   = sck_q;   cs_n_d  = cs_n_q;
    sh_d    = sh_q;     cnt_d   = cnt_q;   bitc_d  = bitc_q;  rx_d    = rx_q;
    bidx_d  = bidx_q;   lg_d    = lg_q;    alen4_d = alen4_q; dum_d   = dum_q;
    burst_d = burst_q;  addr_d  = addr_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_CMD;
          cs_n_d  = ~cs_sel;
          sh_d    = {cfg.opcode, 24'h0};
          cnt_d   = CNT_W'(7);
          half_d  = 1'b0;
          sck_d   = 1'b0;
          bitc_d  = '0;
          bidx_d  = '0;
          lg_d    = mode_lg(cfg.mode);
          alen4_d = |cfg.alen;
          dum_d   = cfg.dummy;
          burst_d = (cfg.burst == 2'b11);
          addr_d  = flash_addr;
        end
      end
      PH_GAP: phase_d = PH_IDLE;
      default: begin
        if (!half_q) begin
          sck_d  = 1'b1;
          half_d = 1'b1;
        end else begin
          sck_d  = 1'b0;
          half_d = 1'b0;
          if (phase_q == PH_DATA) begin
            rx_d = rx_nxt;
            if (bitc_q == last_bit) begin
              bitc_d = '0;
              bidx_d = bidx_q + 4'd1;
            end else begin
              bitc_d = bitc_q + 3'd1;
            end
          end
          if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
            sh_d  = (phase_q == PH_CMD) ? (sh_q << 1) : (sh_q << lane_n);
          end else begin
            case (phase_q)
              PH_CMD: begin
                phase_d = PH_ADDR;
                cnt_d   = addr_beats - CNT_W'(1);
                sh_d    = alen4_q ? addr_q : {addr_q[23:0], 8'h0};
              end
              PH_ADDR: begin
                if (dum_q != 2'd0) begin
                  phase_d = PH_DUMMY;
                  cnt_d   = dum_beats - CNT_W'(1);
                end else begin
                  phase_d = PH_DATA;
                  cnt_d   = data_beats - CNT_W'(1);
                end
              end
              PH_DUMMY: begin
                phase_d = PH_DATA;
                cnt_d   = data_beats - CNT_W'(1);
              end
              default: begin
                phase_d = PH_GAP;
                cs_n_d  = '1;
              end
            endcase
          end
        end
      end
    endcase
  end

  assign seq_en = (phase_q != PH_IDLE) || start;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; half_q  <= 1'b0; sck_q   <= 1'b0; cs_n_q <= '1;
      sh_q    <= '0;      cnt_q   <= '0;   bitc_q  <= '0;   rx_q   <= '0;
      bidx_q  <= '0;      lg_q    <= '0;   alen4_q <= 1'b0; dum_q  <= '0;
      burst_q <= 1'b0;    addr_q  <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d; half_q  <= half_d; sck_q   <= sck_d;   cs_n_q <= cs_n_d;
      sh_q    <= sh_d;    cnt_q   <= cnt_d;  bitc_q  <= bitc_d;  rx_q   <= rx_d;
      bidx_q  <= bidx_d;  lg_q    <= lg_d;   alen4_q <= alen4_d; dum_q  <= dum_d;
      burst_q <= burst_d; addr_q  <= addr_d;
    end
  end

  // pad drive
  always_comb begin
    io_out = '0;
    io_oe  = '0;
    case (phase_q)
      PH_CMD: begin
        io_out[0] = sh_q[31];
        io_oe     = 4'b0001;
      end
      PH_ADDR: begin
        case (lg_q)
          2'd0: begin io_out[0]   = sh_q[31];    io_oe = 4'b0001; end
          2'd1: begin io_out[1:0] = sh_q[31:30]; io_oe = 4'b0011; end
          default: begin io_out   = sh_q[31:28]; io_oe = 4'b1111; end
        endcase
      end
      default: ;
    endcase
  end

  assign idle     = (phase_q == PH_IDLE);
  assign sck      = sck_q;
  assign cs_n     = cs_n_q;
  assign byte_vld = byte_end;
  assign byte_dat = rx_nxt;
  assign byte_idx = bidx_q;

  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_q));

  assert_sck_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_q) |-> !sck_q);

  assert_sck_short_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |=> !sck_q);

endmodule

// File: rtl/mmflash_rd_xlat.sv
module mmflash_rd_xlat
  import mmflash_pkg::*;
#(
  parameter int ADDR_W     = 29,
  parameter int WIN_W      = 27,
  parameter int NUM_CS     = 4,
  parameter int DUMMY_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              spi_sck,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);

  localparam int CNT_W = 8;

  logic [1:0]        rst_ff;
  logic              rst_sync_n;
  rd_cfg_t           cfg;
  logic [NUM_CS-1:0] cs_sel;
  logic [31:0]       flash_addr;
  logic [3:0]        byte_sel;
  logic              seq_idle, start;
  logic              byte_vld;
  logic [7:0]        byte_dat;
  logic [3:0]        byte_idx;
  logic [3:0]        tgt_q;
  logic              ready_q, ready_d;
  logic [7:0]        rdata_q;
  logic              hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  mmflash_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .cfg_word (cfg_rdata),
    .cfg      (cfg)
  );

  mmflash_addr_map #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .NUM_CS (NUM_CS)
  ) u_map (
    .addr       (rd_addr),
    .burst      (cfg.burst == 2'b11),
    .cs_sel     (cs_sel),
    .flash_addr (flash_addr),
    .byte_sel   (byte_sel)
  );

  assign start = rd_req && seq_idle;

  mmflash_spi_seq #(
    .NUM_CS     (NUM_CS),
    .DUMMY_UNIT (DUMMY_UNIT),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .cfg        (cfg),
    .flash_addr (flash_addr),
    .cs_sel     (cs_sel),
    .io_in      (spi_io_in),
    .idle       (seq_idle),
    .sck        (spi_sck),
    .cs_n       (spi_cs_n),
    .io_out     (spi_io_out),
    .io_oe      (spi_io_oe),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat),
    .byte_idx   (byte_idx)
  );

  assign hit     = byte_vld && (byte_idx == tgt_q);
  assign ready_d = hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_q   <= '0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= ready_d;
      if (start) tgt_q   <= byte_sel;
      if (hit)   rdata_q <= byte_dat;
    end
  end

  assign rd_ready = ready_q;
  assign rd_data  = rdata_q;

  assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_ready |=> !rd_ready);

  assert_ready_after_select_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_ready |-> !(&$past(spi_cs_n)));

endmodule

// File: tb/mmflash_rd_xlat_bench.sv
module mmflash_rd_xlat_bench;
  localparam int AW  = 29;
  localparam int NCS = 4;
  localparam int NV  = 8;

  localparam logic [31:0] VCFG [NV] = '{
    32'h0000_0003, 32'h0300_100B, 32'h0001_113C, 32'h0300_22EB,
    32'h0001_32EC, 32'h0300_01BB, 32'h0000_0313, 32'h0100_0003 };
  localparam logic [AW-1:0] VADDR [NV] = '{
    29'h0000_1234, 29'h0812_3457, 29'h1504_5679, 29'h1800_00AF,
    29'h0700_0003, 29'h0800_0010, 29'h1000_0021, 29'h1FFF_FFFF };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, cfg_we, rd_req, rd_ready, spi_sck;
  logic [31:0]    cfg_wdata, cfg_rdata;
  logic [AW-1:0]  rd_addr;
  logic [7:0]     rd_data;
  logic [NCS-1:0] spi_cs_n;
  logic [3:0]     spi_io_out, spi_io_oe, flash_io;

  int checks = 0;
  int errors = 0;

  mmflash_rd_xlat u_mmflash_rd_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(flash_io));

  // behavioural flash model
  int          edge_n, m_cs, exp_L, exp_abits, exp_hdr;
  logic [7:0]  m_op;
  logic [31:0] m_addr;
  bit          oe_bad;

  function automatic logic [7:0] mem_byte(input int cs, input logic [31:0] a);
    logic [7:0] p;
    p = 8'(a[7:0] * 8'd7);
    return p ^ a[15:8] ^ a[23:16] ^ 8'(cs * 53);
  endfunction

  always @(posedge spi_sck) begin
    edge_n = edge_n + 1;
    for (int c = 0; c < NCS; c++) if (!spi_cs_n[c]) m_cs = c;
    if (edge_n <= 8) m_op = {m_op[6:0], spi_io_out[0]};
    else if (edge_n <= 8 + exp_abits / exp_L)
      m_addr = (m_addr << exp_L) | 32'(spi_io_out & 4'((1 << exp_L) - 1));
    else if (spi_io_oe != 4'b0000) oe_bad = 1'b1;
  end

  always @(negedge spi_sck) begin
    if (edge_n >= exp_hdr) begin
      int k, bi, j;
      logic [7:0] b;
      logic [3:0] ch;
      k  = edge_n - exp_hdr;
      bi = k / (8 / exp_L);
      j  = k % (8 / exp_L);
      b  = mem_byte(m_cs, m_addr + 32'(bi));
      ch = 4'((b >> (8 - exp_L * (j + 1))) & 8'((1 << exp_L) - 1));
      if (exp_L == 1) flash_io = {2'b00, ch[0], 1'b0};
      else            flash_io = ch;
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output bit cs_low);
    bit to;
    edge_n = 0; m_op = '0; m_addr = '0; oe_bad = 1'b0; m_cs = -1;
    d = '0; cs_low = 1'b0; to = 1'b1;
    @(negedge clk); rd_req = 1'b1; rd_addr = a;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rd_ready) begin d = rd_data; cs_low = (spi_cs_n != '1); to = 1'b0; break; end
    end
    rd_req = 1'b0;
    for (int i = 0; i < 3000 && spi_cs_n != '1; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (to) begin errors++; $display("FAIL R7 ready timeout actual=0 expected=1"); end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit cs_low;
    cfg_we = 1'b0; cfg_wdata = '0; rd_req = 1'b0; rd_addr = '0; flash_io = '0;
    edge_n = 0; exp_L = 1; exp_abits = 24; exp_hdr = 1000; m_cs = 0; oe_bad = 1'b0;
    m_op = '0; m_addr = '0;
    apply_reset();

    // R1 reset state
    check_eq("R1 cs_n", 32'(spi_cs_n), 32'hF);
    check_eq("R1 sck", 32'(spi_sck), 0);
    check_eq("R1 ready", 32'(rd_ready), 0);
    check_eq("R1 cfg", cfg_rdata, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] c, off, eaddr, sa;
      int lg, dd, cs, nb, sel;
      bit a4, bst;
      c   = VCFG[i];
      lg  = (c[9:8] == 2'd1) ? 1 : (c[9:8] == 2'd2) ? 2 : 0;
      a4  = (c[17:16] != 2'd0);
      dd  = int'(c[13:12]);
      bst = (c[25:24] == 2'b11);
      exp_L     = 1 << lg;
      exp_abits = a4 ? 32 : 24;
      exp_hdr   = 8 + exp_abits / exp_L + dd * 8;
      cs    = int'(VADDR[i][28:27]);
      off   = 32'(VADDR[i][26:0]);
      eaddr = a4 ? off : (off & 32'h00FF_FFFF);
      sa    = bst ? (eaddr & ~32'hF) : eaddr;
      sel   = bst ? int'(off[3:0]) : 0;
      nb    = bst ? 16 : 1;
      cfg_write(c);
      do_read(VADDR[i], d, cs_low);
      check_eq($sformatf("R2 opcode v%0d", i), 32'(m_op), 32'(c[7:0]));
      check_eq($sformatf("R4 address v%0d", i), m_addr, sa);
      check_eq($sformatf("R3 R5 R6 sck count v%0d", i), edge_n, exp_hdr + nb * 8 / exp_L);
      check_eq($sformatf("R5 lanes released v%0d", i), 32'(oe_bad), 0);
      check_eq($sformatf("R8 select v%0d", i), m_cs, cs);
      check_eq($sformatf("R3 R6 R7 data v%0d", i), 32'(d), 32'(mem_byte(cs, sa + 32'(sel))));
      if (bst && sel != 15)
        check_eq($sformatf("R7 early ready v%0d", i), 32'(cs_low), 1);
    end

    // R9 undefined bits read as zero
    cfg_write(32'h7FFF_FFFF);
    check_eq("R9 mask", cfg_rdata, 32'h0303_33FF);

    // R9 lock then ignored write
    cfg_write(32'h8000_0003);
    cfg_write(32'h0000_00AA);
    check_eq("R9 locked value", cfg_rdata, 32'h8000_0003);
    exp_L = 1; exp_abits = 24; exp_hdr = 32;
    do_read(29'h0000_0055, d, cs_low);
    check_eq("R9 locked opcode used", 32'(m_op), 32'h03);
    check_eq("R9 locked data", 32'(d), 32'(mem_byte(0, 32'h55)));

    // R9 reset releases lock
    apply_reset();
    check_eq("R9 reset clears", cfg_rdata, 0);
    cfg_write(32'h0000_00AA);
    check_eq("R9 writable after reset", cfg_rdata, 32'h0000_00AA);
    check_eq("R1 R10 sck idle", 32'(spi_sck), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule